// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division on two 32-bit operands over several clock cycles. Its results do not go to the general register file. They go to a private pair of result registers, HI and LO. A multiply leaves the full 64-bit product across the pair. A divide leaves the quotient in LO and the remainder in HI. Both operations have a signed and an unsigned form.

Inside the block, a shift-add datapath and a restoring-division datapath share one set of working registers. Each datapath retires one bit per cycle. While an operation is in flight the block raises `busy`. A read of HI or LO through the read port is held off until the new result has been written. A request that arrives while the unit is occupied is dropped, and the block reports it with a one-cycle error pulse.

Top module: `muldiv_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `req_err`, `rd_ready` and `rd_data` are zero, and both HI and LO read back as zero.
- R2: `req_op` is encoded as 00 signed multiply, 01 unsigned multiply, 10 signed divide and 11 unsigned divide. A request is accepted on a clock edge where `req_valid` is high and `busy` is low. `busy` is high from the next cycle for exactly 32 cycles.
- R3: A multiply writes the 64-bit product to the pair, with bits 63:32 in HI and bits 31:0 in LO. Op 00 treats the operands as two's complement and op 01 treats them as unsigned.
- R4: An unsigned divide (op 11) writes the quotient to LO and the remainder to HI.
- R5: In a signed divide (op 10) the quotient truncates toward zero and the remainder carries the sign of the dividend. The case 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: A divide by zero, signed or unsigned, completes in the normal time with no trap. It leaves LO = 0xFFFFFFFF and HI equal to the original dividend.
- R7: A read selects LO when `rd_sel` is 0 and HI when `rd_sel` is 1. When `rd_en` is high on an edge where `busy` is low, `rd_ready` is high in the next cycle and `rd_data` holds the selected register. When `busy` is high on that edge, `rd_ready` is low in the next cycle.
- R8: A request made while `busy` is high is ignored, and the in-flight result is unchanged. `req_err` is high for exactly the one cycle after that edge.
- R9: HI and LO change only at the edge that completes an operation. A read after completion returns the new value, and repeated reads return the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_op | input | 2 | Operation code (see R2) |
| opa | input | 32 | Multiplicand or dividend |
| opb | input | 32 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| req_err | output | 1 | Pulse: request dropped while busy |
| rd_en | input | 1 | Read request for HI or LO |
| rd_sel | input | 1 | 0 selects LO, 1 selects HI |
| rd_data | output | 32 | Registered read data |
| rd_ready | output | 1 | `rd_data` is valid this cycle |

## Verification
The assertions assume a reset that lasts at least two cycles before the first request, so that every `$past` term sees defined register values. They also assume that `req_valid`, `rd_en` and the operands are driven to known levels at every clock edge. The stimulus drives every input on the falling clock edge, holds reset for several cycles and never leaves an input undriven. It covers the ignored-request case by raising `req_valid` once in the middle of an operation, and the read stall by holding `rd_en` high across a whole operation.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MULU = 2'b01,
    OP_DIV  = 2'b10,
    OP_DIVU = 2'b11
  } md_op_e;
endpackage

// File: rtl/md_mul_step.sv
// One shift-add multiply iteration: conditionally add, then shift right.
module md_mul_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] acc,
  input  logic [W-1:0] mlr,
  input  logic [W-1:0] mcand,
  output logic [W-1:0] acc_nx,
  output logic [W-1:0] mlr_nx
);
  logic [W:0] sum;

  always_comb begin
    sum    = {1'b0, acc} + (mlr[0] ? {1'b0, mcand} : '0);
    acc_nx = sum[W:1];
    mlr_nx = {sum[0], mlr[W-1:1]};
  end
endmodule

// File: rtl/md_div_step.sv
// One restoring-division iteration: shift in a dividend bit, trial subtract.
module md_div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] quo,
  input  logic [W-1:0] dvs,
  output logic [W-1:0] rem_nx,
  output logic [W-1:0] quo_nx
);
  logic [W:0] shf;
  logic [W:0] dif;
  logic       fits;

  always_comb begin
    shf    = {rem, quo[W-1]};
    dif    = shf - {1'b0, dvs};
    // an overflowed shift is always >= any W-bit divisor
    fits   = shf[W] | ~dif[W];
    rem_nx = fits ? dif[W-1:0] : shf[W-1:0];
    quo_nx = {quo[W-2:0], fits};
  end
endmodule

// File: rtl/md_hilo.sv
// Result register pair with a registered, busy-interlocked read port.
module md_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] hi_in,
  input  logic [W-1:0] lo_in,
  input  logic         busy_in,
  input  logic         rd_en,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         rd_ready
);
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (wr_en) begin
      hi_q <= hi_in;
      lo_q <= lo_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_ready <= 1'b0;
    end else begin
      rd_ready <= rd_en & ~busy_in;
      if (rd_en && !busy_in) rd_data <= rd_sel ? hi_q : lo_q;
    end
  end

  // R7: data is only presented for a read made while idle
  a_r7_ready_src: assert property (@(posedge clk) disable iff (rst)
    rd_ready |-> $past(rd_en) && !$past(busy_in));

  // R7: a read while busy is stalled
  a_r7_stall: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy_in) |=> !rd_ready);

  // R9: the pair never changes while the unit is idle
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !busy_in |=> $stable(hi_q) && $stable(lo_q));
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [1:0]   req_op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         req_err,
  input  logic         rd_en,
  input  logic         rd_sel,
  output logic [W-1:0] rd_data,
  output logic         rd_ready
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt;
  logic          is_div;
  logic          neg_lo, neg_hi;
  logic [W-1:0]  p_hi, p_lo, opnd;

  // request decode and operand magnitudes
  md_op_e        op;
  logic          start, sgn, div_in, a_neg, b_neg;
  logic [W-1:0]  a_mag, b_mag;

  always_comb begin
    op     = md_op_e'(req_op);
    start  = req_valid & ~busy;
    sgn    = (op == OP_MUL) || (op == OP_DIV);
    div_in = (op == OP_DIV) || (op == OP_DIVU);
    a_neg  = sgn & opa[W-1];
    b_neg  = sgn & opb[W-1];
    a_mag  = a_neg ? -opa : opa;
    b_mag  = b_neg ? -opb : opb;
  end

  // iteration datapaths
  logic [W-1:0] m_hi_nx, m_lo_nx, d_hi_nx, d_lo_nx;

  md_mul_step #(.W(W)) u_mul (
    .acc(p_hi), .mlr(p_lo), .mcand(opnd),
    .acc_nx(m_hi_nx), .mlr_nx(m_lo_nx)
  );

  md_div_step #(.W(W)) u_div (
    .rem(p_hi), .quo(p_lo), .dvs(opnd),
    .rem_nx(d_hi_nx), .quo_nx(d_lo_nx)
  );

  // final sign correction on the last iteration
  logic [2*W-1:0] prod;
  logic [W-1:0]   res_hi, res_lo;
  logic           done;

  always_comb begin
    done = busy && (cnt == LAST);
    prod = {m_hi_nx, m_lo_nx};
    if (neg_lo && !is_div) prod = -prod;
    if (is_div) begin
      res_lo = neg_lo ? -d_lo_nx : d_lo_nx;
      res_hi = neg_hi ? -d_hi_nx : d_hi_nx;
    end else begin
      res_lo = prod[W-1:0];
      res_hi = prod[2*W-1:W];
    end
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      req_err <= 1'b0;
      cnt     <= '0;
      is_div  <= 1'b0;
      neg_lo  <= 1'b0;
      neg_hi  <= 1'b0;
      p_hi    <= '0;
      p_lo    <= '0;
      opnd    <= '0;
    end else begin
      req_err <= req_valid & busy;
      if (start) begin
        busy   <= 1'b1;
        cnt    <= '0;
        is_div <= div_in;
        p_hi   <= '0;
        p_lo   <= a_mag;
        opnd   <= b_mag;
        neg_lo <= div_in ? ((a_neg ^ b_neg) && (opb != '0)) : (a_neg ^ b_neg);
        neg_hi <= div_in & a_neg;
      end else if (busy) begin
        p_hi <= is_div ? d_hi_nx : m_hi_nx;
        p_lo <= is_div ? d_lo_nx : m_lo_nx;
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) busy <= 1'b0;
      end
    end
  end

  md_hilo #(.W(W)) u_hilo (
    .clk(clk), .rst(rst), .wr_en(done),
    .hi_in(res_hi), .lo_in(res_lo), .busy_in(busy),
    .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_ready(rd_ready)
  );

  // R2: an idle-time request always starts an operation
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  // R8: the error pulse follows only a request made while busy
  a_r8_err_src: assert property (@(posedge clk) disable iff (rst)
    req_err |-> $past(req_valid) && $past(busy));

  // R8: a dropped request does not end or restart the running operation
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid && cnt != LAST) |=> busy && (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/sim_muldiv_unit.sv
`timescale 1ns/1ps
module sim_muldiv_unit;
  localparam int W = 32;
  localparam int NV = 12;
  localparam int WDOG = 100000;

  // {op, a, b, expected HI, expected LO}
  localparam logic [129:0] VEC [NV] = '{
    {2'b00, 32'h00000007, 32'hFFFFFFFD, 32'hFFFFFFFF, 32'hFFFFFFEB},
    {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001},
    {2'b01, 32'h00010000, 32'h00010000, 32'h00000001, 32'h00000000},
    {2'b00, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000},
    {2'b00, 32'h00000000, 32'hDEADBEEF, 32'h00000000, 32'h00000000},
    {2'b10, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD},
    {2'b10, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD},
    {2'b11, 32'hFFFFFFF9, 32'h00000002, 32'h00000001, 32'h7FFFFFFC},
    {2'b10, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000},
    {2'b11, 32'h00000064, 32'h00000007, 32'h00000002, 32'h0000000E},
    {2'b10, 32'hFFFFFFF9, 32'h00000000, 32'hFFFFFFF9, 32'hFFFFFFFF},
    {2'b11, 32'h12345678, 32'h00000000, 32'h12345678, 32'hFFFFFFFF}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic [1:0]   req_op = 2'b00;
  logic [W-1:0] opa = '0, opb = '0;
  logic         busy, req_err;
  logic         rd_en = 1'b0, rd_sel = 1'b0;
  logic [W-1:0] rd_data;
  logic         rd_ready;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  muldiv_unit #(.W(W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .opa(opa), .opb(opb), .busy(busy), .req_err(req_err),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_ready(rd_ready)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  // issue one request; returns the number of cycles busy was seen high
  task automatic issue(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       output int bcnt);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; opa = a; opb = b;
    @(negedge clk);
    req_valid = 1'b0;
    bcnt = 0;
    while (busy) begin
      bcnt++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic sel, output logic [W-1:0] v, output logic ok);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    ok = rd_ready;
    v = rd_data;
  endtask

  initial begin
    logic [W-1:0] v, v2;
    logic ok;
    int bc;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 req_err", 64'(req_err), 64'd0);
    chk("R1 rd_ready", 64'(rd_ready), 64'd0);
    chk("R1 rd_data", 64'(rd_data), 64'd0);
    rd(1'b0, v, ok);
    chk("R1 LO", {31'd0, ok, v}, {31'd0, 1'b1, 32'd0});
    rd(1'b1, v, ok);
    chk("R1 HI", {31'd0, ok, v}, {31'd0, 1'b1, 32'd0});

    // vector table: R3 multiply, R4/R5/R6 divide, R2 busy length
    for (int i = 0; i < NV; i++) begin
      logic [129:0] e;
      string tg;
      e = VEC[i];
      issue(e[129:128], e[127:96], e[95:64], bc);
      chk("R2 busy cycles", 64'(bc), 64'd32);
      if (!e[129]) tg = "R3";
      else if (e[95:64] == '0) tg = "R6";
      else if (!e[128]) tg = "R5";
      else tg = "R4";
      rd(1'b1, v, ok);
      chk({tg, " HI"}, {31'd0, ok, v}, {31'd0, 1'b1, e[63:32]});
      rd(1'b0, v, ok);
      chk({tg, " LO"}, {31'd0, ok, v}, {31'd0, 1'b1, e[31:0]});
    end

    // R9: repeated reads of a settled value are stable
    rd(1'b0, v, ok);
    rd(1'b0, v2, ok);
    chk("R9 repeat read", 64'(v2), 64'(v));

    // R8: request while busy is dropped and flagged
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b01; opa = 32'd6; opb = 32'd7;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_op = 2'b11; opa = 32'd100; opb = 32'd3;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 err pulse", 64'(req_err), 64'd1);
    @(negedge clk);
    chk("R8 err one cycle", 64'(req_err), 64'd0);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8 no restart", 64'(busy), 64'd0);
    rd(1'b1, v, ok);
    chk("R8 HI kept", {31'd0, ok, v}, {31'd0, 1'b1, 32'd0});
    rd(1'b0, v, ok);
    chk("R8 LO kept", {31'd0, ok, v}, {31'd0, 1'b1, 32'd42});

    // R7: read held across an operation stalls until the result is written
    begin
      int waited;
      logic early;
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b00; opa = 32'hFFFFFFFF; opb = 32'h00000005;
      @(negedge clk);
      req_valid = 1'b0;
      rd_en = 1'b1; rd_sel = 1'b0;
      waited = 0;
      early = 1'b0;
      while (!rd_ready && waited < 100) begin
        @(negedge clk);
        waited++;
        if (rd_ready && busy) early = 1'b1;
      end
      rd_en = 1'b0;
      chk("R7 no ready while busy", 64'(early), 64'd0);
      chk("R7 stall length", 64'(waited), 64'd33);
      chk("R7 stalled read data", 64'(rd_data), 64'hFFFFFFFB);
      rd(1'b1, v, ok);
      chk("R7 HI select", {31'd0, ok, v}, {31'd0, 1'b1, 32'hFFFFFFFF});
    end

    summary();
    $finish;
  end
endmodule